// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches sixteen external interrupt lines and turns pin transitions into latched interrupt requests. Each line n takes pin n from one of several GPIO ports, and a per-line port index chooses which one. The chosen pin passes through a synchronizer, and the block then looks for rising and falling transitions. Each direction has its own enable. A detected edge sets a sticky pending bit, and software clears that bit by writing a 1 to it. A per-line enable mask decides whether a pending line reaches the request outputs. The outputs are grouped as follows: the five lowest lines each get their own wire, lines 5 to 9 share one wire, and lines 10 to 15 share another.

Software reaches all configuration and pending state through a simple single-cycle register bus. Writes are taken on the clock edge while `bus_we` is high, and reads are combinational from `bus_addr`. A build-time option keeps separate pending registers for rising and falling edges, so software can tell which direction fired.

Top module: `eic_ctrl`

## Requirements
- R1: After reset, every register reads 0 and all request outputs are low. The register addresses are: 0 rising enable, 1 falling enable, 2 mask, 3 pending, 4 falling pending, and 5 to 8 source-select words 0 to 3. Unused addresses read 0.
- R2: When bit n of the rising-enable register (address 0) is set, a low-to-high change on line n's selected pin sets pending bit n. A high-to-low change with only that enable set leaves the bit clear.
- R3: When bit n of the falling-enable register (address 1) is set, a high-to-low change sets pending bit n. A low-to-high change with only that enable set leaves the bit clear.
- R4: With both enables set for a line, either direction of change sets its pending bit.
- R5: Writing 1 to bit n of address 3 clears pending bit n. Writing 0 to any pending bit leaves it unchanged.
- R6: A pending line drives a request only while its bit in the mask register (address 2) is 1. While the line is masked, its pending bit still latches.
- R7: Line n takes its port index from select word n/4, at bits [4*(n mod 4)+3 : 4*(n mod 4)]. Port p's pin n is input bit p*16+n of `port_pins`. Pins on unselected ports have no effect.
- R8: `irq_single[n]` is driven by line n for n from 0 to 4. `irq_mid` is the OR of lines 5 to 9, and `irq_hi` is the OR of lines 10 to 15. Each is qualified by pending AND mask.
- R9: If an edge and a write-1 clear hit the same pending bit on the same clock edge, the bit stays set.
- R10: With SPLIT_PEND=1, rising edges latch at address 3 and falling edges latch at address 4. Each is cleared by writing 1, and the request is (rising OR falling pending) AND mask. With SPLIT_PEND=0, address 4 reads 0.
- R11: A pin change made between clock edges shows in the pending bit after the third following rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_pins | input | NUM_PORTS*16 | Raw pins, port p pin n at bit p*16+n |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq_single | output | 5 | Dedicated requests for lines 0 to 4 |
| irq_mid | output | 1 | Shared request for lines 5 to 9 |
| irq_hi | output | 1 | Shared request for lines 10 to 15 |

## Verification
The pins are driven with single rising transitions, single falling transitions and full pulses, each against rising-only, falling-only and both-edge configurations. This shows whether each direction's enable gates only its own edge. The same edges are placed on the selected port and on an unselected port, which shows that the per-line mux decodes its field from the right word and bit position. Lines from every request group are raised one at a time, which separates dedicated wires from shared ones. A clear write is timed to land on the same clock edge as a new edge, which tells the edge-wins ordering apart from the clear-wins ordering. A second instance built with split pending shows which register each direction lands in.

// File: rtl/eic_pkg.sv
package eic_pkg;
   localparam int unsigned LINES        = 16;
   localparam int unsigned SEL_W        = 4;
   localparam int unsigned DATA_W       = 16;
   localparam int unsigned ADDR_W       = 4;
   localparam int unsigned SEL_PER_WORD = DATA_W / SEL_W;
   localparam int unsigned SEL_WORDS    = LINES / SEL_PER_WORD;
   localparam int unsigned N_SINGLE     = 5;
   localparam int unsigned MID_LAST     = 9;

   localparam logic [ADDR_W-1:0] A_RISE  = 4'd0;
   localparam logic [ADDR_W-1:0] A_FALL  = 4'd1;
   localparam logic [ADDR_W-1:0] A_MASK  = 4'd2;
   localparam logic [ADDR_W-1:0] A_PEND  = 4'd3;
   localparam logic [ADDR_W-1:0] A_PENDF = 4'd4;
   localparam logic [ADDR_W-1:0] A_SEL0  = 4'd5;
endpackage

// File: rtl/eic_line_src.sv
// One line: port mux, synchronizer chain, and edge detection.
module eic_line_src #(
   parameter int unsigned NUM_PORTS   = 4,
   parameter int unsigned SEL_W       = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PORTS-1:0] pins,
   input  logic [SEL_W-1:0]     sel,
   output logic                 rise_hit,
   output logic                 fall_hit
);
   logic               raw;
   logic [SYNC_STAGES:0] sh;

   // A port index that names no port feeds a constant 0.
   always_comb begin
      raw = 1'b0;
      for (int p = 0; p < int'(NUM_PORTS); p++) begin
         if (sel == SEL_W'(p)) raw = pins[p];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SYNC_STAGES-1:0], raw};
   end

   // sh[SYNC_STAGES-1] is the synchronized level; sh[SYNC_STAGES] is that level one clock earlier.
   assign rise_hit =  sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
   assign fall_hit = ~sh[SYNC_STAGES-1] &  sh[SYNC_STAGES];
endmodule

// File: rtl/eic_regs.sv
// Configuration registers, pending latches, and the read mux.
module eic_regs
   import eic_pkg::*;
#(
   parameter bit SPLIT_PEND = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [DATA_W-1:0]      wdata,
   input  logic [LINES-1:0]       rise_hit,
   input  logic [LINES-1:0]       fall_hit,
   output logic [LINES-1:0]       rise_en,
   output logic [LINES-1:0]       fall_en,
   output logic [LINES-1:0]       mask,
   output logic [LINES-1:0]       pend_r,
   output logic [LINES-1:0]       pend_f,
   output logic [LINES*SEL_W-1:0] sel_flat,
   output logic [DATA_W-1:0]      rdata
);
   logic [LINES-1:0] hit_r, hit_f;
   logic [LINES-1:0] clr_r, clr_f;

   assign hit_r = rise_hit & rise_en;
   assign hit_f = fall_hit & fall_en;
   assign clr_r = (we && addr == A_PEND)  ? wdata : '0;
   assign clr_f = (we && addr == A_PENDF) ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_en <= '0;
         fall_en <= '0;
         mask    <= '0;
      end else if (we) begin
         if (addr == A_RISE) rise_en <= wdata;
         if (addr == A_FALL) fall_en <= wdata;
         if (addr == A_MASK) mask    <= wdata;
      end
   end

   for (genvar k = 0; k < int'(SEL_WORDS); k++) begin : g_selw
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) word_q <= '0;
         else if (we && addr == A_SEL0 + ADDR_W'(k)) word_q <= wdata;
      end
      assign sel_flat[k*DATA_W +: DATA_W] = word_q;
   end

   // A set takes priority over a clear on the same edge.
   if (SPLIT_PEND) begin : g_split
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_r <= '0;
            pend_f <= '0;
         end else begin
            pend_r <= (pend_r & ~clr_r) | hit_r;
            pend_f <= (pend_f & ~clr_f) | hit_f;
         end
      end
   end else begin : g_joint
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend_r <= '0;
         else        pend_r <= (pend_r & ~clr_r) | hit_r | hit_f;
      end
      assign pend_f = '0;
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         A_RISE:  rdata = rise_en;
         A_FALL:  rdata = fall_en;
         A_MASK:  rdata = mask;
         A_PEND:  rdata = pend_r;
         A_PENDF: rdata = pend_f;
         default: rdata = '0;
      endcase
      for (int k = 0; k < int'(SEL_WORDS); k++) begin
         if (addr == A_SEL0 + ADDR_W'(k)) rdata = sel_flat[k*DATA_W +: DATA_W];
      end
   end
endmodule

// File: rtl/eic_irq_group.sv
// Applies the mask and merges lines onto the request wires.
module eic_irq_group #(
   parameter int unsigned LINES    = 16,
   parameter int unsigned N_SINGLE = 5,
   parameter int unsigned MID_LAST = 9
) (
   input  logic [LINES-1:0]    pend_any,
   input  logic [LINES-1:0]    mask,
   output logic [N_SINGLE-1:0] irq_single,
   output logic                irq_mid,
   output logic                irq_hi
);
   logic [LINES-1:0] act;
   assign act = pend_any & mask;

   for (genvar i = 0; i < int'(N_SINGLE); i++) begin : g_single
      assign irq_single[i] = act[i];
   end

   assign irq_mid = |act[MID_LAST:N_SINGLE];
   assign irq_hi  = |act[LINES-1:MID_LAST+1];
endmodule

// File: rtl/eic_ctrl.sv
module eic_ctrl
   import eic_pkg::*;
#(
   parameter int unsigned NUM_PORTS   = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          SPLIT_PEND  = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_PORTS*LINES-1:0] port_pins,
   input  logic                       bus_we,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [DATA_W-1:0]          bus_wdata,
   output logic [DATA_W-1:0]          bus_rdata,
   output logic [N_SINGLE-1:0]        irq_single,
   output logic                       irq_mid,
   output logic                       irq_hi
);
   if (LINES != DATA_W)                        $error("eic_ctrl: one pending bit per data bit required");
   if (SEL_PER_WORD * SEL_WORDS != LINES)      $error("eic_ctrl: select words must cover all lines");
   if (NUM_PORTS < 1 || NUM_PORTS > (1 << SEL_W)) $error("eic_ctrl: NUM_PORTS out of range");
   if (SYNC_STAGES < 2)                        $error("eic_ctrl: at least two synchronizer stages");
   if (MID_LAST < N_SINGLE || MID_LAST >= LINES - 1) $error("eic_ctrl: bad request grouping");

   logic [LINES-1:0]       rise_hit, fall_hit;
   logic [LINES-1:0]       rise_en, fall_en, mask_q;
   logic [LINES-1:0]       pend_r, pend_f, pend_any;
   logic [LINES*SEL_W-1:0] sel_flat;

   for (genvar n = 0; n < int'(LINES); n++) begin : g_line
      logic [NUM_PORTS-1:0] lp;
      for (genvar p = 0; p < int'(NUM_PORTS); p++) begin : g_port
         assign lp[p] = port_pins[p*LINES + n];
      end
      eic_line_src #(
         .NUM_PORTS   (NUM_PORTS),
         .SEL_W       (SEL_W),
         .SYNC_STAGES (SYNC_STAGES)
      ) u_src (
         .clk      (clk),
         .rst_n    (rst_n),
         .pins     (lp),
         .sel      (sel_flat[n*SEL_W +: SEL_W]),
         .rise_hit (rise_hit[n]),
         .fall_hit (fall_hit[n])
      );
   end

   eic_regs #(.SPLIT_PEND(SPLIT_PEND)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (bus_we),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .rise_hit (rise_hit),
      .fall_hit (fall_hit),
      .rise_en  (rise_en),
      .fall_en  (fall_en),
      .mask     (mask_q),
      .pend_r   (pend_r),
      .pend_f   (pend_f),
      .sel_flat (sel_flat),
      .rdata    (bus_rdata)
   );

   assign pend_any = pend_r | pend_f;

   eic_irq_group #(
      .LINES    (LINES),
      .N_SINGLE (N_SINGLE),
      .MID_LAST (MID_LAST)
   ) u_grp (
      .pend_any   (pend_any),
      .mask       (mask_q),
      .irq_single (irq_single),
      .irq_mid    (irq_mid),
      .irq_hi     (irq_hi)
   );
endmodule

// File: rtl/eic_ctrl_chk.sv
module eic_ctrl_chk
   import eic_pkg::*;
(
   input logic                clk,
   input logic                rst_n,
   input logic                bus_we,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic [LINES-1:0]    rise_en,
   input logic [LINES-1:0]    fall_en,
   input logic [LINES-1:0]    mask,
   input logic [LINES-1:0]    pend_any,
   input logic [N_SINGLE-1:0] irq_single,
   input logic                irq_mid,
   input logic                irq_hi
);
   logic [LINES-1:0] clr_any, keep;
   assign clr_any = (bus_we && (bus_addr == A_PEND || bus_addr == A_PENDF)) ? bus_wdata : '0;
   assign keep    = pend_any & ~clr_any;

   AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_any & $past(keep)) == $past(keep)));  // R5

   AST_PEND_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((pend_any & ~$past(pend_any)) & ~$past(rise_en | fall_en)) == '0));  // R2

   AST_IRQ_SINGLE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_single & ~mask[N_SINGLE-1:0]) == '0));  // R6

   AST_IRQ_MID_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_mid |-> |(pend_any[MID_LAST:N_SINGLE] & mask[MID_LAST:N_SINGLE]));  // R8

   AST_IRQ_HI_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_hi |-> |(pend_any[LINES-1:MID_LAST+1] & mask[LINES-1:MID_LAST+1]));  // R8
endmodule

bind eic_ctrl eic_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .rise_en    (rise_en),
   .fall_en    (fall_en),
   .mask       (mask_q),
   .pend_any   (pend_any),
   .irq_single (irq_single),
   .irq_mid    (irq_mid),
   .irq_hi     (irq_hi)
);

// File: tb/eic_ctrl_bench.sv
`timescale 1ns/100ps
module eic_ctrl_bench;
   localparam int NP = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [NP*16-1:0] pins = '0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] rdata_a, rdata_b;
   logic [4:0]  single_a, single_b;
   logic        mid_a, mid_b, hi_a, hi_b;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   eic_ctrl #(.NUM_PORTS(NP), .SPLIT_PEND(1'b0)) u_eic_ctrl (
      .clk(clk), .rst_n(rst_n), .port_pins(pins), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
      .irq_single(single_a), .irq_mid(mid_a), .irq_hi(hi_a));

   eic_ctrl #(.NUM_PORTS(NP), .SPLIT_PEND(1'b1)) u_eic_ctrl_split (
      .clk(clk), .rst_n(rst_n), .port_pins(pins), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
      .irq_single(single_b), .irq_mid(mid_b), .irq_hi(hi_b));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] va, output logic [15:0] vb);
      bus_addr = a;
      #1;
      va = rdata_a;
      vb = rdata_b;
   endtask

   // Change one pin, then wait until three rising edges have passed.
   task automatic pin_edge(input int port, input int line, input logic v);
      @(negedge clk);
      pins[port*16 + line] = v;
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [6:0] irq_a();
      return {hi_a, mid_a, single_a};
   endfunction

   task automatic quiesce();
      wr(4'd0, 16'h0); wr(4'd1, 16'h0); wr(4'd2, 16'h0);
      for (int k = 0; k < 4; k++) wr(4'(5 + k), 16'h0);
      @(negedge clk);
      pins = '0;
      repeat (4) @(negedge clk);
      wr(4'd3, 16'hFFFF); wr(4'd4, 16'hFFFF);
   endtask

   task automatic t_reset();
      logic [15:0] va, vb;
      for (int a = 0; a < 16; a++) begin
         rd(4'(a), va, vb);
         chk("R1 reset reg", {16'h0, va}, 32'h0);
         chk("R1 reset reg split", {16'h0, vb}, 32'h0);
      end
      chk("R1 reset irq", {25'h0, irq_a()}, 32'h0);
   endtask

   task automatic t_rise();
      logic [15:0] va, vb;
      quiesce();
      wr(4'd0, 16'h0001); wr(4'd2, 16'h0001);
      @(negedge clk);
      pins[0] = 1'b1;
      repeat (2) @(posedge clk);
      #1; rd(4'd3, va, vb);
      chk("R11 not after second edge", {16'h0, va}, 32'h0);
      @(posedge clk);
      #1; rd(4'd3, va, vb);
      chk("R11 R2 set after third edge", {16'h0, va}, 32'h0001);
      chk("R2 irq line0", {25'h0, irq_a()}, 32'h01);
      wr(4'd3, 16'h0001);
      pin_edge(0, 0, 1'b0);
      rd(4'd3, va, vb);
      chk("R2 falling ignored", {16'h0, va}, 32'h0);
   endtask

   task automatic t_fall();
      logic [15:0] va, vb;
      quiesce();
      wr(4'd1, 16'h0002);
      pin_edge(0, 1, 1'b1);
      rd(4'd3, va, vb);
      chk("R3 rising ignored", {16'h0, va}, 32'h0);
      pin_edge(0, 1, 1'b0);
      rd(4'd3, va, vb);
      chk("R3 falling sets", {16'h0, va}, 32'h0002);
   endtask

   task automatic t_both();
      logic [15:0] va, vb;
      quiesce();
      wr(4'd0, 16'h0004); wr(4'd1, 16'h0004);
      pin_edge(0, 2, 1'b1);
      rd(4'd3, va, vb);
      chk("R4 rise sets", {16'h0, va}, 32'h0004);
      wr(4'd3, 16'h0004);
      rd(4'd3, va, vb);
      chk("R4 cleared", {16'h0, va}, 32'h0);
      pin_edge(0, 2, 1'b0);
      rd(4'd3, va, vb);
      chk("R4 fall sets", {16'h0, va}, 32'h0004);
   endtask

   task automatic t_clear();
      logic [15:0] va, vb;
      quiesce();
      wr(4'd0, 16'h0018);
      pin_edge(0, 3, 1'b1);
      pin_edge(0, 4, 1'b1);
      rd(4'd3, va, vb);
      chk("R5 both set", {16'h0, va}, 32'h0018);
      wr(4'd3, 16'h0000);
      rd(4'd3, va, vb);
      chk("R5 zero write no effect", {16'h0, va}, 32'h0018);
      wr(4'd3, 16'h0008);
      rd(4'd3, va, vb);
      chk("R5 one bit cleared", {16'h0, va}, 32'h0010);
      wr(4'd3, 16'h0010);
      rd(4'd3, va, vb);
      chk("R5 all cleared", {16'h0, va}, 32'h0);
   endtask

   task automatic t_mask();
      logic [15:0] va, vb;
      quiesce();
      wr(4'd0, 16'h0040);
      pin_edge(0, 6, 1'b1);
      rd(4'd3, va, vb);
      chk("R6 latches while masked", {16'h0, va}, 32'h0040);
      chk("R6 masked no irq", {25'h0, irq_a()}, 32'h0);
      wr(4'd2, 16'h0040);
      chk("R6 unmasked irq", {25'h0, irq_a()}, 32'h20);
      wr(4'd2, 16'h0000);
      chk("R6 remasked no irq", {25'h0, irq_a()}, 32'h0);
   endtask

   task automatic t_group();
      int lines [7] = '{0, 1, 2, 3, 4, 7, 12};
      logic [6:0] exp;
      quiesce();
      wr(4'd0, 16'hFFFF); wr(4'd2, 16'hFFFF);
      foreach (lines[i]) begin
         int n = lines[i];
         exp = (n < 5) ? 7'(1 << n) : (n < 10) ? 7'h20 : 7'h40;
         pin_edge(0, n, 1'b1);
         chk($sformatf("R8 group line %0d", n), {25'h0, irq_a()}, {25'h0, exp});
         wr(4'd3, 16'hFFFF);
         pin_edge(0, n, 1'b0);
      end
   endtask

   task automatic t_select();
      logic [15:0] va, vb;
      quiesce();
      wr(4'd7, 16'h0020);
      wr(4'd8, 16'h0030);
      rd(4'd7, va, vb);
      chk("R7 select word2 readback", {16'h0, va}, 32'h0020);
      wr(4'd0, 16'h2200);
      pin_edge(0, 9, 1'b1);
      pin_edge(0, 13, 1'b1);
      rd(4'd3, va, vb);
      chk("R7 unselected port ignored", {16'h0, va}, 32'h0);
      pin_edge(2, 9, 1'b1);
      rd(4'd3, va, vb);
      chk("R7 line9 from port2", {16'h0, va}, 32'h0200);
      pin_edge(3, 13, 1'b1);
      rd(4'd3, va, vb);
      chk("R7 line13 from port3", {16'h0, va}, 32'h2200);
   endtask

   task automatic t_collide();
      logic [15:0] va, vb;
      quiesce();
      wr(4'd0, 16'h0400);
      pin_edge(0, 10, 1'b1);
      pin_edge(0, 10, 1'b0);
      @(negedge clk);
      pins[10] = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = 4'd3; bus_wdata = 16'h0400;
      @(negedge clk);
      bus_we = 1'b0;
      rd(4'd3, va, vb);
      chk("R9 edge beats clear", {16'h0, va}, 32'h0400);
      wr(4'd3, 16'h0400);
      rd(4'd3, va, vb);
      chk("R9 later clear works", {16'h0, va}, 32'h0);
   endtask

   task automatic t_split();
      logic [15:0] va, vb;
      quiesce();
      wr(4'd0, 16'h0800); wr(4'd1, 16'h0800); wr(4'd2, 16'h0800);
      pin_edge(0, 11, 1'b1);
      rd(4'd3, va, vb);
      chk("R10 rising reg", {16'h0, vb}, 32'h0800);
      rd(4'd4, va, vb);
      chk("R10 falling reg empty", {16'h0, vb}, 32'h0);
      chk("R10 unified addr4 zero", {16'h0, va}, 32'h0);
      pin_edge(0, 11, 1'b0);
      rd(4'd4, va, vb);
      chk("R10 falling reg set", {16'h0, vb}, 32'h0800);
      wr(4'd3, 16'h0800);
      rd(4'd3, va, vb);
      chk("R10 rising cleared", {16'h0, vb}, 32'h0);
      chk("R10 irq held by falling", {31'h0, hi_b}, 32'h1);
      wr(4'd4, 16'h0800);
      chk("R10 irq drops", {31'h0, hi_b}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rise();
      t_fall();
      t_both();
      t_clear();
      t_mask();
      t_group();
      t_select();
      t_collide();
      t_split();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule